// File: doc/BRIEF.md
# Hash Engine Command Sequence Checker

This block sits beside a sponge-construction hash and MAC engine. It watches the commands that software issues to that engine. It follows the engine through its phases in a six-state machine: idle, message feed, processing, absorbed, squeezing and terminal error. It decides each cycle whether the present command is legal. When it is not, or when a fault makes going on unsafe, the block stops the command with `block_o` and keeps its phase where it is. On the edge that ends the cycle, it records an error flag and a prioritised error code.

At the moment a hash is started, the block checks the configuration. The mode and output-strength pair must be one the engine supports. When MAC operation is on, the six-byte function-name prefix must match the encoded MAC name. A prefix mismatch is reported but does not stop the start. Two multi-bit control inputs act on the state register directly. The escalation input forces the terminal-error state. The clear request brings the machine back to idle.

Top module: `hash_cmd_guard`

## Requirements
- R1: While `rst_ni` is low at a clock edge, the state returns to idle (`phase_o` = 0) and `err_o` and `err_code_o` are cleared to 0. Phase codes: idle 0, message feed 1, processing 2, absorbed 3, squeezing 4, terminal error 5. Any encoding from 6 to 7 behaves as terminal error.
- R2: In idle, command Start (1) moves the state to message feed only when `app_active_i` is 0. With `app_active_i` at 1, Start leaves the state in idle and raises no error.
- R3: In message feed, command Process (2) moves the state to processing. Processing moves to absorbed only when `absorbed_i` equals 4'b0110 exactly. Any other value leaves it in processing.
- R4: In absorbed, command ManualRun (3) moves the state to squeezing and command Done (4) moves it to idle. Squeezing returns to absorbed when `perm_done_i` is 1.
- R5: The legal commands depend on the state. Idle takes None (0) and Start. Message feed takes None and Process. Absorbed takes None, ManualRun and Done. Processing and squeezing take only None. Any other code, including 5 to 7, is a sequence error: error code 1, `block_o` high, and the state held. The terminal-error state flags no command.
- R6: On an idle-to-feed start, the mode/strength pair is checked. Mode codes: SHA3 0, SHAKE 2, cSHAKE 3; code 1 is reserved. Strength codes: 128 = 0, 224 = 1, 256 = 2, 384 = 3, 512 = 4. SHA3 allows 224, 256, 384 and 512. SHAKE and cSHAKE allow 128 and 256. Any other pair is a mode/strength error, code 2. It blocks the start unless `allow_unsup_i` is 1, in which case the start proceeds and the error is still reported.
- R7: On an idle-to-feed start with `kmac_en_i` at 1, `prefix_i` must equal 48'h43414D4B2001. Byte 0 is bits 7:0 and holds 0x01, followed by 0x20, 'K', 'M', 'A' and 'C'. A mismatch gives code 3 and does not block. With `kmac_en_i` at 0, the prefix is ignored.
- R8: `rng_unready_i` at 1 is an entropy error, code 4. It blocks the command and holds the state.
- R9: When several errors occur in one cycle, the code reported is the first of: sequence (1), mode/strength (2), prefix (3), entropy (4).
- R10: `escalate_i` at any value other than 4'b1001 sends the state to terminal error at the next edge. This happens from every state and overrides blocking and the clear request. Terminal error stays until a clear or a reset.
- R11: `clear_err_i` equal to 4'b0110, with no escalation, sends the state to idle at the next edge. This happens from every state, including terminal error, and overrides blocking.
- R12: `block_o` is combinational and reflects the present cycle's inputs. `err_o` and `err_code_o` are registered: they show that cycle's errors after the next edge and read 0 after a cycle with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Software command code |
| mode_i | input | 2 | Hash mode code |
| strength_i | input | 3 | Output strength code |
| prefix_i | input | 48 | Function-name prefix bytes, byte 0 in bits 7:0 |
| kmac_en_i | input | 1 | MAC operation enabled |
| allow_unsup_i | input | 1 | Let an unsupported mode/strength start proceed |
| app_active_i | input | 1 | An application interface holds the engine |
| absorbed_i | input | 4 | Multi-bit absorbed indication (true = 4'b0110) |
| perm_done_i | input | 1 | Permutation finished pulse |
| rng_unready_i | input | 1 | Entropy-not-ready error |
| escalate_i | input | 4 | Multi-bit escalation (off = 4'b1001) |
| clear_err_i | input | 4 | Multi-bit clear request (true = 4'b0110) |
| err_o | output | 1 | Registered error flag |
| err_code_o | output | 3 | Registered prioritised error code |
| block_o | output | 1 | The present command is refused |
| phase_o | output | 3 | Present state of the machine |

## Verification
The hardest situations to reach are the cycles where several error sources coincide with a control override. Two examples are a sequence error arriving together with escalation, and an unsupported mode together with an entropy fault during a start. Random stimulus rarely lines these up, because the machine must first be walked into the right phase. Directed sequences therefore drive the machine through feed, processing, absorbed and squeezing and then stack the faults in one cycle. Random cycles, weighted toward commands that are legal in the current phase, then cover the long tail against a reference model in the bench.

// File: rtl/hcg_pkg.sv
// Shared encodings of the hash command sequence checker.
// Assumes: command, mode and strength codes arrive already decoded from
// software, and multi-bit flags use the patterns given here.
package hcg_pkg;

    localparam int CMD_W   = 3;
    localparam int MODE_W  = 2;
    localparam int STR_W   = 3;
    localparam int PHASE_W = 3;
    localparam int CODE_W  = 3;
    localparam int MB_W    = 4;
    localparam int PFX_BYTES = 6;

    localparam logic [MB_W-1:0] MB_TRUE = 4'b0110;
    localparam logic [MB_W-1:0] ESC_OFF = 4'b1001;

    // Encoded MAC function name, byte 0 in the low bits.
    localparam logic [PFX_BYTES*8-1:0] MAC_NAME = 48'h43414D4B2001;

    localparam logic [CMD_W-1:0] CMD_NONE    = 3'd0;
    localparam logic [CMD_W-1:0] CMD_START   = 3'd1;
    localparam logic [CMD_W-1:0] CMD_PROCESS = 3'd2;
    localparam logic [CMD_W-1:0] CMD_RUN     = 3'd3;
    localparam logic [CMD_W-1:0] CMD_DONE    = 3'd4;

    localparam logic [MODE_W-1:0] MODE_SHA3   = 2'd0;
    localparam logic [MODE_W-1:0] MODE_SHAKE  = 2'd2;
    localparam logic [MODE_W-1:0] MODE_CSHAKE = 2'd3;

    localparam logic [STR_W-1:0] STR_128 = 3'd0;
    localparam logic [STR_W-1:0] STR_224 = 3'd1;
    localparam logic [STR_W-1:0] STR_256 = 3'd2;
    localparam logic [STR_W-1:0] STR_384 = 3'd3;
    localparam logic [STR_W-1:0] STR_512 = 3'd4;

    localparam logic [PHASE_W-1:0] PH_IDLE = 3'd0;
    localparam logic [PHASE_W-1:0] PH_FEED = 3'd1;
    localparam logic [PHASE_W-1:0] PH_PROC = 3'd2;
    localparam logic [PHASE_W-1:0] PH_ABS  = 3'd3;
    localparam logic [PHASE_W-1:0] PH_SQZ  = 3'd4;
    localparam logic [PHASE_W-1:0] PH_TERM = 3'd5;

    localparam logic [CODE_W-1:0] ERR_NONE = 3'd0;
    localparam logic [CODE_W-1:0] ERR_SEQ  = 3'd1;
    localparam logic [CODE_W-1:0] ERR_MODE = 3'd2;
    localparam logic [CODE_W-1:0] ERR_PFX  = 3'd3;
    localparam logic [CODE_W-1:0] ERR_RNG  = 3'd4;

endpackage

// File: rtl/hcg_cmd_rules.sv
// Decides whether the present command is legal in the present phase.
// Assumes: an unknown phase encoding and terminal error flag nothing.
module hcg_cmd_rules
    import hcg_pkg::*;
(
    input  logic [PHASE_W-1:0] phase_i,
    input  logic [CMD_W-1:0]   cmd_i,
    output logic               seq_err_o
);

    // Purpose: per-phase table of accepted commands.
    always_comb begin
        seq_err_o = 1'b0;
        case (phase_i)
            PH_IDLE: seq_err_o = !(cmd_i == CMD_NONE || cmd_i == CMD_START);
            PH_FEED: seq_err_o = !(cmd_i == CMD_NONE || cmd_i == CMD_PROCESS);
            PH_PROC: seq_err_o = (cmd_i != CMD_NONE);
            PH_ABS:  seq_err_o = !(cmd_i == CMD_NONE || cmd_i == CMD_RUN ||
                                   cmd_i == CMD_DONE);
            PH_SQZ:  seq_err_o = (cmd_i != CMD_NONE);
            default: seq_err_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/hcg_cfg_rules.sv
// Validates mode/strength and the MAC prefix when a hash is started.
// Assumes: check_i is high only in the cycle of an idle-to-feed start.
module hcg_cfg_rules
    import hcg_pkg::*;
#(
    parameter int NBYTES = PFX_BYTES
) (
    input  logic                  check_i,
    input  logic                  kmac_en_i,
    input  logic [MODE_W-1:0]     mode_i,
    input  logic [STR_W-1:0]      strength_i,
    input  logic [NBYTES*8-1:0]   prefix_i,
    input  logic [NBYTES*8-1:0]   name_i,
    output logic                  mode_err_o,
    output logic                  pfx_err_o
);

    logic [NBYTES-1:0] byte_ok;
    logic              pair_ok;

    // Purpose: one comparator per prefix byte.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign byte_ok[b] = (prefix_i[b*8 +: 8] == name_i[b*8 +: 8]);
    end

    // Purpose: table of supported mode and strength pairs.
    always_comb begin
        pair_ok = 1'b0;
        case (mode_i)
            MODE_SHA3: pair_ok = (strength_i == STR_224) || (strength_i == STR_256) ||
                                 (strength_i == STR_384) || (strength_i == STR_512);
            MODE_SHAKE, MODE_CSHAKE:
                       pair_ok = (strength_i == STR_128) || (strength_i == STR_256);
            default:   pair_ok = 1'b0;
        endcase
    end

    assign mode_err_o = check_i && !pair_ok;
    assign pfx_err_o  = check_i && kmac_en_i && !(&byte_ok);

endmodule

// File: rtl/hcg_phase_fsm.sv
// Phase register of the command checker with block, escalation and clear.
// Assumes: block_i may depend on start_o but never on the final next state.
module hcg_phase_fsm
    import hcg_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [CMD_W-1:0]   cmd_i,
    input  logic               app_active_i,
    input  logic [MB_W-1:0]    absorbed_i,
    input  logic               perm_done_i,
    input  logic [MB_W-1:0]    escalate_i,
    input  logic [MB_W-1:0]    clear_err_i,
    input  logic               block_i,
    output logic               start_o,
    output logic [PHASE_W-1:0] phase_o
);

    logic [PHASE_W-1:0] phase_q, step_next, phase_d;

    // Purpose: transition wanted by the command flow alone.
    always_comb begin
        step_next = PH_TERM;
        case (phase_q)
            PH_IDLE: step_next = (cmd_i == CMD_START && !app_active_i) ? PH_FEED : PH_IDLE;
            PH_FEED: step_next = (cmd_i == CMD_PROCESS) ? PH_PROC : PH_FEED;
            PH_PROC: step_next = (absorbed_i == MB_TRUE) ? PH_ABS : PH_PROC;
            PH_ABS: begin
                if (cmd_i == CMD_RUN)       step_next = PH_SQZ;
                else if (cmd_i == CMD_DONE) step_next = PH_IDLE;
                else                        step_next = PH_ABS;
            end
            PH_SQZ:  step_next = perm_done_i ? PH_ABS : PH_SQZ;
            default: step_next = PH_TERM;
        endcase
    end

    assign start_o = (phase_q == PH_IDLE) && (step_next == PH_FEED);

    // Purpose: apply blocking, then escalation and clear overrides.
    always_comb begin
        if (block_i) phase_d = (phase_q > PH_TERM) ? PH_TERM : phase_q;
        else         phase_d = step_next;
        if (escalate_i != ESC_OFF)     phase_d = PH_TERM;
        else if (clear_err_i == MB_TRUE) phase_d = PH_IDLE;
    end

    // Purpose: state register with synchronous reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) phase_q <= PH_IDLE;
        else         phase_q <= phase_d;
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/hash_cmd_guard.sv
// Command sequence checker for a sponge hash/MAC engine: tracks phase,
// refuses illegal commands and reports a prioritised, registered error code.
// Assumes: one command per cycle; prefix byte 0 in the low bits.
module hash_cmd_guard
    import hcg_pkg::*;
#(
    parameter int NBYTES = PFX_BYTES,
    localparam int PW    = NBYTES * 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [CMD_W-1:0]   cmd_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [STR_W-1:0]   strength_i,
    input  logic [PW-1:0]      prefix_i,
    input  logic               kmac_en_i,
    input  logic               allow_unsup_i,
    input  logic               app_active_i,
    input  logic [MB_W-1:0]    absorbed_i,
    input  logic               perm_done_i,
    input  logic               rng_unready_i,
    input  logic [MB_W-1:0]    escalate_i,
    input  logic [MB_W-1:0]    clear_err_i,
    output logic               err_o,
    output logic [CODE_W-1:0]  err_code_o,
    output logic               block_o,
    output logic [PHASE_W-1:0] phase_o
);

    logic              seq_err, mode_err, pfx_err, start_w;
    logic [CODE_W-1:0] code_d, code_q;
    logic              err_q;

    hcg_cmd_rules u_cmd (
        .phase_i   (phase_o),
        .cmd_i     (cmd_i),
        .seq_err_o (seq_err)
    );

    hcg_cfg_rules #(.NBYTES(NBYTES)) u_cfg (
        .check_i    (start_w),
        .kmac_en_i  (kmac_en_i),
        .mode_i     (mode_i),
        .strength_i (strength_i),
        .prefix_i   (prefix_i),
        .name_i     (PW'(MAC_NAME)),
        .mode_err_o (mode_err),
        .pfx_err_o  (pfx_err)
    );

    hcg_phase_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cmd_i        (cmd_i),
        .app_active_i (app_active_i),
        .absorbed_i   (absorbed_i),
        .perm_done_i  (perm_done_i),
        .escalate_i   (escalate_i),
        .clear_err_i  (clear_err_i),
        .block_i      (block_o),
        .start_o      (start_w),
        .phase_o      (phase_o)
    );

    // Purpose: errors that refuse the command; a prefix error does not.
    assign block_o = seq_err || (mode_err && !allow_unsup_i) || rng_unready_i;

    // Purpose: fixed-priority error code.
    always_comb begin
        if (seq_err)            code_d = ERR_SEQ;
        else if (mode_err)      code_d = ERR_MODE;
        else if (pfx_err)       code_d = ERR_PFX;
        else if (rng_unready_i) code_d = ERR_RNG;
        else                    code_d = ERR_NONE;
    end

    // Purpose: register the error report for one cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            err_q  <= 1'b0;
            code_q <= ERR_NONE;
        end else begin
            err_q  <= (code_d != ERR_NONE);
            code_q <= code_d;
        end
    end

    assign err_o      = err_q;
    assign err_code_o = code_q;

endmodule

// File: rtl/hash_cmd_guard_chk.sv
// Temporal checks on the command sequence checker's ports.
// Assumes: bound to every instance of hash_cmd_guard.
module hash_cmd_guard_chk
    import hcg_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic [CMD_W-1:0]   cmd_i,
    input logic               app_active_i,
    input logic [MB_W-1:0]    absorbed_i,
    input logic               rng_unready_i,
    input logic [MB_W-1:0]    escalate_i,
    input logic [MB_W-1:0]    clear_err_i,
    input logic               err_o,
    input logic [CODE_W-1:0]  err_code_o,
    input logic               block_o,
    input logic [PHASE_W-1:0] phase_o
);

    // R1: first cycle after reset shows idle with no error.
    a_r1_reset_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rst_ni) |-> (phase_o == PH_IDLE) && !err_o && (err_code_o == ERR_NONE));

    // R10: escalation always lands in terminal error.
    a_r10_escalate_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (escalate_i != ESC_OFF) |=> (phase_o == PH_TERM));

    // R11: clear without escalation lands in idle.
    a_r11_clear_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (escalate_i == ESC_OFF) && (clear_err_i == MB_TRUE) |=> (phase_o == PH_IDLE));

    // R5: a blocked command leaves a valid phase unchanged.
    a_r5_block_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        block_o && (escalate_i == ESC_OFF) && (clear_err_i != MB_TRUE) && (phase_o <= PH_TERM)
        |=> (phase_o == $past(phase_o)));

    // R8: entropy fault always refuses the command and reports an error.
    a_r8_rng_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rng_unready_i |-> block_o ##1 err_o);

    // R2: an unblocked start with no interface active enters message feed.
    a_r2_start_feed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == PH_IDLE) && (cmd_i == CMD_START) && !app_active_i && !block_o &&
        (escalate_i == ESC_OFF) && (clear_err_i != MB_TRUE) |=> (phase_o == PH_FEED));

    // R3: strict absorbed indication leaves processing.
    a_r3_absorb: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == PH_PROC) && (absorbed_i == MB_TRUE) && !block_o &&
        (escalate_i == ESC_OFF) && (clear_err_i != MB_TRUE) |=> (phase_o == PH_ABS));

    // R12: the error flag and a non-zero code move together.
    a_r12_flag_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o == (err_code_o != ERR_NONE));

endmodule

bind hash_cmd_guard hash_cmd_guard_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_i         (cmd_i),
    .app_active_i  (app_active_i),
    .absorbed_i    (absorbed_i),
    .rng_unready_i (rng_unready_i),
    .escalate_i    (escalate_i),
    .clear_err_i   (clear_err_i),
    .err_o         (err_o),
    .err_code_o    (err_code_o),
    .block_o       (block_o),
    .phase_o       (phase_o)
);

// File: tb/hash_cmd_guard_test.sv
module hash_cmd_guard_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] GOOD_PFX = 48'h43414D4B2001;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [2:0]  cmd_i;
    logic [1:0]  mode_i;
    logic [2:0]  strength_i;
    logic [47:0] prefix_i;
    logic        kmac_en_i, allow_unsup_i, app_active_i, perm_done_i, rng_unready_i;
    logic [3:0]  absorbed_i, escalate_i, clear_err_i;
    logic        err_o, block_o;
    logic [2:0]  err_code_o, phase_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [2:0] m_ph;
    logic       m_err;
    logic [2:0] m_code;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    hash_cmd_guard uut (
        .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .mode_i(mode_i),
        .strength_i(strength_i), .prefix_i(prefix_i), .kmac_en_i(kmac_en_i),
        .allow_unsup_i(allow_unsup_i), .app_active_i(app_active_i),
        .absorbed_i(absorbed_i), .perm_done_i(perm_done_i),
        .rng_unready_i(rng_unready_i), .escalate_i(escalate_i),
        .clear_err_i(clear_err_i), .err_o(err_o), .err_code_o(err_code_o),
        .block_o(block_o), .phase_o(phase_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit pair_legal(input logic [1:0] m, input logic [2:0] s);
        if (m == 2'd0) return (s >= 3'd1 && s <= 3'd4);
        if (m == 2'd2 || m == 2'd3) return (s == 3'd0 || s == 3'd2);
        return 1'b0;
    endfunction

    // Reference model from the requirements.
    function automatic void ref_eval(output logic [2:0] nx, output logic blk,
                                     output logic [2:0] code);
        logic seq, start, me, pe;
        logic [2:0] raw;
        case (m_ph)
            3'd0: seq = !(cmd_i == 0 || cmd_i == 1);
            3'd1: seq = !(cmd_i == 0 || cmd_i == 2);
            3'd2, 3'd4: seq = (cmd_i != 0);
            3'd3: seq = !(cmd_i == 0 || cmd_i == 3 || cmd_i == 4);
            default: seq = 1'b0;
        endcase
        start = (m_ph == 0) && (cmd_i == 1) && !app_active_i;
        me = start && !pair_legal(mode_i, strength_i);
        pe = start && kmac_en_i && (prefix_i != GOOD_PFX);
        blk = seq || (me && !allow_unsup_i) || rng_unready_i;
        code = seq ? 3'd1 : me ? 3'd2 : pe ? 3'd3 : rng_unready_i ? 3'd4 : 3'd0;
        case (m_ph)
            3'd0: raw = start ? 3'd1 : 3'd0;
            3'd1: raw = (cmd_i == 2) ? 3'd2 : 3'd1;
            3'd2: raw = (absorbed_i == 4'b0110) ? 3'd3 : 3'd2;
            3'd3: raw = (cmd_i == 3) ? 3'd4 : (cmd_i == 4) ? 3'd0 : 3'd3;
            3'd4: raw = perm_done_i ? 3'd3 : 3'd4;
            default: raw = 3'd5;
        endcase
        nx = blk ? m_ph : raw;
        if (escalate_i != 4'b1001) nx = 3'd5;
        else if (clear_err_i == 4'b0110) nx = 3'd0;
    endfunction

    task automatic quiet();
        cmd_i = 0; mode_i = 0; strength_i = 3'd2; prefix_i = GOOD_PFX;
        kmac_en_i = 0; allow_unsup_i = 0; app_active_i = 0; perm_done_i = 0;
        rng_unready_i = 0; absorbed_i = 4'b1001; escalate_i = 4'b1001; clear_err_i = 0;
    endtask

    // One cycle: check block now, then state and registered error after the edge.
    task automatic step(input string tag);
        logic [2:0] nx, code;
        logic blk;
        ref_eval(nx, blk, code);
        #1;
        chk(tag, "block_o", int'(block_o), int'(blk));
        @(posedge clk_i);
        m_ph = nx; m_err = (code != 0); m_code = code;
        @(negedge clk_i);
        chk(tag, "phase_o", int'(phase_o), int'(m_ph));
        chk(tag, "err_o", int'(err_o), int'(m_err));
        chk(tag, "err_code_o", int'(err_code_o), int'(m_code));
        quiet();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        quiet();
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        m_ph = 0;
        // R1: reset state
        chk("R1", "phase_o", int'(phase_o), 0);
        chk("R1", "err_o", int'(err_o), 0);
        chk("R1", "err_code_o", int'(err_code_o), 0);

        cmd_i = 1; app_active_i = 1; step("R2");        // held in idle
        cmd_i = 1; step("R2");                          // enter feed
        cmd_i = 1; step("R5");                          // start in feed
        cmd_i = 7; step("R5");                          // unknown code
        cmd_i = 2; step("R3");                          // processing
        absorbed_i = 4'b0111; step("R3");               // not strict
        cmd_i = 3; step("R5");                          // run in processing
        absorbed_i = 4'b0110; step("R3");               // absorbed
        cmd_i = 3; step("R4");                          // squeeze
        cmd_i = 4; step("R5");                          // done in squeezing
        perm_done_i = 1; step("R4");
        cmd_i = 4; step("R4");                          // back to idle
        cmd_i = 1; mode_i = 1; step("R6");              // reserved mode
        cmd_i = 1; mode_i = 0; strength_i = 0; step("R6");
        cmd_i = 1; mode_i = 2; strength_i = 1; step("R6");
        cmd_i = 1; mode_i = 3; strength_i = 4; allow_unsup_i = 1; step("R6");
        clear_err_i = 4'b0110; step("R11");             // feed -> idle
        cmd_i = 1; kmac_en_i = 1; prefix_i = GOOD_PFX ^ 48'h1; step("R7");
        clear_err_i = 4'b0110; step("R11");
        cmd_i = 1; prefix_i = GOOD_PFX ^ 48'h0000_0100_0000; step("R7");
        clear_err_i = 4'b0110; step("R11");
        cmd_i = 1; kmac_en_i = 1; mode_i = 0; strength_i = 3; step("R7");
        clear_err_i = 4'b0110; step("R11");
        cmd_i = 1; prefix_i = 48'h0; kmac_en_i = 0; mode_i = 2; strength_i = 0; step("R7");
        clear_err_i = 4'b0110; step("R11");
        cmd_i = 1; mode_i = 1; kmac_en_i = 1; prefix_i = 0; rng_unready_i = 1; step("R9");
        rng_unready_i = 1; step("R8");
        cmd_i = 1; rng_unready_i = 1; step("R8");
        cmd_i = 1; step("R2");
        cmd_i = 4; rng_unready_i = 1; step("R9");
        cmd_i = 3; escalate_i = 4'b0000; step("R10");   // escalate over block
        cmd_i = 5; step("R10");                         // terminal flags none
        escalate_i = 4'b1011; clear_err_i = 4'b0110; step("R10");
        clear_err_i = 4'b0110; step("R11");

        // R12: weighted random cycles against the reference model.
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            case (m_ph)
                3'd0: cmd_i = (r < 60) ? 3'd1 : (r < 90) ? 3'd0 : 3'($urandom_range(0, 7));
                3'd1: cmd_i = (r < 50) ? 3'd2 : (r < 90) ? 3'd0 : 3'($urandom_range(0, 7));
                3'd3: cmd_i = (r < 40) ? 3'd3 : (r < 70) ? 3'd4 : (r < 92) ? 3'd0
                                       : 3'($urandom_range(0, 7));
                default: cmd_i = (r < 92) ? 3'd0 : 3'($urandom_range(0, 7));
            endcase
            mode_i = 2'($urandom_range(0, 3));
            strength_i = 3'($urandom_range(0, 5));
            prefix_i = ($urandom_range(0, 9) == 0) ? GOOD_PFX ^ (48'h1 << $urandom_range(0, 47))
                                                   : GOOD_PFX;
            kmac_en_i = 1'($urandom_range(0, 1));
            allow_unsup_i = ($urandom_range(0, 3) == 0);
            app_active_i = ($urandom_range(0, 4) == 0);
            absorbed_i = ($urandom_range(0, 2) == 0) ? 4'b0110 : 4'($urandom_range(0, 15));
            perm_done_i = ($urandom_range(0, 2) == 0);
            rng_unready_i = ($urandom_range(0, 30) == 0);
            escalate_i = ($urandom_range(0, 80) == 0) ? 4'($urandom_range(0, 15)) : 4'b1001;
            clear_err_i = (m_ph == 5 && $urandom_range(0, 3) == 0) ||
                          ($urandom_range(0, 100) == 0) ? 4'b0110 : 4'($urandom_range(0, 5));
            step("R12");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule